// File: doc/BRIEF.md
# Four-Channel Match Timer

This block holds a free-running 32-bit up-counter and four 32-bit compare channels. The counter advances by one on each single-cycle reference tick. On each tick cycle, every channel compares its compare value with the counter. When a channel matches and its enable bit is set, its status bit is set and stays set, and the status bits drive four interrupt request lines. Software clears a status bit by writing 1 to it.

Channel 3 can also act as a watchdog. Once software arms the watchdog, it cannot be disarmed except by reset. A channel 3 match while it is armed raises a reset request that stays high until reset.

Software reaches all state through a simple single-cycle register bus with a word address. All logic runs on the bus clock. The watchdog is a three-state machine:
- DISARMED goes to ARMED on a write of 1 to bit 0 of the watchdog register (transition ARM).
- ARMED goes to TRIPPED on a channel 3 match during a tick (transition BITE).
- TRIPPED holds until reset (transition HOLD).
- Reset returns the machine to DISARMED.

Top module: `match_timer_top`

## Requirements
- R1: After reset, all registers read zero, `irq` is 0 and `wdog_rst_req` is 0. This covers the four compare values, the counter, the status, the enable and the watchdog register.
- R2: The counter holds its value except in a cycle with `tick` high. After such a cycle it reads one higher. It wraps from 0xFFFFFFFF to 0 with no flag.
- R3: A write to word address 4 loads the counter with the written value. This load takes priority over a tick in the same cycle.
- R4: The compare registers for channels 0, 1, 2 and 3 sit at word addresses 0, 1, 2 and 3 (byte offsets 0x0, 0x4, 0x8, 0xC). Each reads back the full 32-bit value written to it.
- R5: In a cycle with `tick` high, status bit i is set at the clock edge if compare value i equals the counter and enable bit i (word address 6, bit i) is 1. Status bit i is visible on `irq[i]` and at word address 5, bit i, from the next cycle. A channel whose enable bit is 0 never sets its status bit.
- R6: Clearing an enable bit leaves an already-set status bit set.
- R7: Writing 1 to bit i of word address 5 clears status bit i. Writing 0 to a bit has no effect. If a clear and a new qualifying match on the same channel fall in the same cycle, the status bit ends set.
- R8: The enable register at word address 6 keeps bits 3:0 of the written value. Bits 31:4 read zero.
- R9: Writing 1 to bit 0 of word address 7 arms the watchdog, and the register reads 1 from then on. Writing 0 does not disarm it. Only reset clears it.
- R10: While the watchdog is armed, a channel 3 match in a tick cycle raises `wdog_rst_req` from the next cycle, whatever enable bit 3 holds. `wdog_rst_req` then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Single-cycle reference tick enable |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| irq | output | 4 | Per-channel sticky status, used as interrupt request |
| wdog_rst_req | output | 1 | Watchdog reset request |

## Verification
The assertions assume the following about the inputs:
- `tick` and bus writes are sampled on the same clock edge, with no other qualifier.
- A write is exactly one cycle of `bus_sel` and `bus_we` together.
- Reset is held low from time zero.

The bench keeps to these assumptions:
- It changes every input one time unit after a rising edge and holds it for a whole cycle.
- It raises `tick` for a single cycle at a time, or together with one deliberate write when it exercises the load and clear priorities.
- It starts with reset asserted.

// File: rtl/mt_pkg.sv
package mt_pkg;
    localparam int unsigned MT_DW     = 32;
    localparam int unsigned MT_NCH    = 4;
    localparam int unsigned MT_ADDR_W = 3;

    typedef enum logic [MT_ADDR_W-1:0] {
        RG_CMP0  = 3'd0,
        RG_CMP1  = 3'd1,
        RG_CMP2  = 3'd2,
        RG_CMP3  = 3'd3,
        RG_COUNT = 3'd4,
        RG_STAT  = 3'd5,
        RG_ENAB  = 3'd6,
        RG_WDOG  = 3'd7
    } mt_reg_e;

    typedef enum logic [1:0] {
        WD_DISARMED = 2'd0,
        WD_ARMED    = 2'd1,
        WD_TRIPPED  = 2'd2
    } wd_state_e;
endpackage

// File: rtl/mt_counter.sv
module mt_counter #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    output logic [DW-1:0] count
);
    localparam logic [DW-1:0] ONE = DW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (tick) begin
            count <= count + ONE;
        end
    end
endmodule

// File: rtl/mt_channels.sv
module mt_channels #(
    parameter int unsigned NCH = 4,
    parameter int unsigned DW  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [DW-1:0]     count,
    input  logic [NCH-1:0]    cmp_we,
    input  logic              en_we,
    input  logic              clr_we,
    input  logic [DW-1:0]     wdata,
    output logic [NCH*DW-1:0] cmp_flat,
    output logic [NCH-1:0]    enable,
    output logic [NCH-1:0]    status,
    output logic [NCH-1:0]    hit
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= '0;
        end else if (en_we) begin
            enable <= wdata[NCH-1:0];
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [DW-1:0] cmp_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_q <= '0;
            end else if (cmp_we[g]) begin
                cmp_q <= wdata;
            end
        end

        assign hit[g] = tick && (cmp_q == count);
        assign cmp_flat[g*DW +: DW] = cmp_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status[g] <= 1'b0;
            end else if (hit[g] && enable[g]) begin
                status[g] <= 1'b1;
            end else if (clr_we && wdata[g]) begin
                status[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mt_watchdog.sv
module mt_watchdog
    import mt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_req,
    input  logic bite,
    output logic armed,
    output logic rst_req
);
    wd_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WD_DISARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_DISARMED: if (arm_req) state_d = WD_ARMED;
            WD_ARMED:    if (bite)    state_d = WD_TRIPPED;
            WD_TRIPPED:  state_d = WD_TRIPPED;
            default:     state_d = WD_DISARMED;
        endcase
    end

    always_comb begin
        armed   = 1'b0;
        rst_req = 1'b0;
        unique case (state_q)
            WD_DISARMED: ;
            WD_ARMED:    armed = 1'b1;
            WD_TRIPPED: begin
                armed   = 1'b1;
                rst_req = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/match_timer_top.sv
module match_timer_top
    import mt_pkg::*;
#(
    parameter int unsigned NCH = MT_NCH,
    parameter int unsigned DW  = MT_DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [MT_ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    output logic [NCH-1:0]       irq,
    output logic                 wdog_rst_req
);
    localparam int unsigned WD_CH = NCH - 1;
    localparam int unsigned PAD_W = DW - NCH;

    logic              wr;
    logic [NCH-1:0]    cmp_we;
    logic              cnt_we, en_we, clr_we, arm_we;
    logic [DW-1:0]     cnt_q;
    logic [NCH*DW-1:0] cmp_flat;
    logic [NCH-1:0]    en_q, stat_q, hit;
    logic              wd_armed;

    assign wr = bus_sel && bus_we;

    for (genvar g = 0; g < NCH; g++) begin : g_dec
        assign cmp_we[g] = wr && (bus_addr == MT_ADDR_W'(g));
    end

    assign cnt_we = wr && (bus_addr == RG_COUNT);
    assign clr_we = wr && (bus_addr == RG_STAT);
    assign en_we  = wr && (bus_addr == RG_ENAB);
    assign arm_we = wr && (bus_addr == RG_WDOG) && bus_wdata[0];

    mt_counter #(.DW(DW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (cnt_we),
        .load_val (bus_wdata),
        .count    (cnt_q)
    );

    mt_channels #(.NCH(NCH), .DW(DW)) u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .count    (cnt_q),
        .cmp_we   (cmp_we),
        .en_we    (en_we),
        .clr_we   (clr_we),
        .wdata    (bus_wdata),
        .cmp_flat (cmp_flat),
        .enable   (en_q),
        .status   (stat_q),
        .hit      (hit)
    );

    mt_watchdog u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_req (arm_we),
        .bite    (hit[WD_CH]),
        .armed   (wd_armed),
        .rst_req (wdog_rst_req)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                RG_CMP0:  bus_rdata = cmp_flat[0*DW +: DW];
                RG_CMP1:  bus_rdata = cmp_flat[1*DW +: DW];
                RG_CMP2:  bus_rdata = cmp_flat[2*DW +: DW];
                RG_CMP3:  bus_rdata = cmp_flat[3*DW +: DW];
                RG_COUNT: bus_rdata = cnt_q;
                RG_STAT:  bus_rdata = {{PAD_W{1'b0}}, stat_q};
                RG_ENAB:  bus_rdata = {{PAD_W{1'b0}}, en_q};
                RG_WDOG:  bus_rdata = {{(DW-1){1'b0}}, wd_armed};
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq = stat_q;
endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
    parameter int unsigned NCH = 4,
    parameter int unsigned DW  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [2:0]        bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic [NCH-1:0]    irq,
    input logic              wdog_rst_req,
    input logic [DW-1:0]     cnt,
    input logic [NCH-1:0]    en,
    input logic [NCH*DW-1:0] cmp_flat
);
    logic cnt_wr, stat_wr;
    assign cnt_wr  = bus_sel && bus_we && (bus_addr == 3'd4);
    assign stat_wr = bus_sel && bus_we && (bus_addr == 3'd5);

    a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !cnt_wr |=> cnt == DW'($past(cnt) + DW'(1)));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !cnt_wr |=> $stable(cnt));

    a_r3_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt == $past(bus_wdata));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        a_r5_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[g]) |-> $past(tick && en[g] && (cmp_flat[g*DW +: DW] == cnt)));

        a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] && !(stat_wr && bus_wdata[g]) |=> irq[g]);

        a_r7_match_wins: assert property (@(posedge clk) disable iff (!rst_n)
            tick && en[g] && (cmp_flat[g*DW +: DW] == cnt) |=> irq[g]);
    end

    a_r10_latched: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst_req |=> wdog_rst_req);

    a_r10_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdog_rst_req) |-> $past(tick && (cmp_flat[(NCH-1)*DW +: DW] == cnt)));
endmodule

bind match_timer_top mt_checker #(.NCH(NCH), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .bus_sel      (bus_sel),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .irq          (irq),
    .wdog_rst_req (wdog_rst_req),
    .cnt          (cnt_q),
    .en           (en_q),
    .cmp_flat     (cmp_flat)
);

// File: tb/test_match_timer_top.sv
module test_match_timer_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;
    logic        wdog_rst_req;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    match_timer_top i_match_timer_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .bus_sel      (bus_sel),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .irq          (irq),
        .wdog_rst_req (wdog_rst_req)
    );

    // {address, write value, expected read-back}
    localparam logic [66:0] VEC [8] = '{
        {3'd0, 32'hA5A5_0001, 32'hA5A5_0001},
        {3'd1, 32'h0000_FFFF, 32'h0000_FFFF},
        {3'd2, 32'h8000_0000, 32'h8000_0000},
        {3'd3, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {3'd4, 32'h1234_5678, 32'h1234_5678},
        {3'd6, 32'hFFFF_FFF5, 32'h0000_0005},
        {3'd6, 32'h0000_0000, 32'h0000_0000},
        {3'd4, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic with_tick);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; tick = with_tick;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #3 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse_tick();
        @(posedge clk); #1 tick = 1'b1;
        @(posedge clk); #1 tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        do_reset();

        // R1: reset state
        #3;
        chk("R1 irq", {28'd0, irq}, 32'd0);
        chk("R1 wdog_rst_req", {31'd0, wdog_rst_req}, 32'd0);
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], v);
            chk($sformatf("R1 reg %0d", a), v, 32'd0);
        end

        // R4 R8 R3: table of write / read-back vectors
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][66:64], VEC[i][63:32], 1'b0);
            rd(VEC[i][66:64], v);
            chk($sformatf("R4/R8/R3 vector %0d", i), v, VEC[i][31:0]);
        end

        // R2: increment and hold
        wr(3'd4, 32'd100, 1'b0);
        pulse_tick();
        rd(3'd4, v);
        chk("R2 increment", v, 32'd101);
        repeat (3) @(posedge clk);
        rd(3'd4, v);
        chk("R2 hold without tick", v, 32'd101);

        // R3: load beats tick in same cycle
        wr(3'd4, 32'd500, 1'b1);
        rd(3'd4, v);
        chk("R3 load priority", v, 32'd500);

        // R2: wrap
        wr(3'd4, 32'hFFFF_FFFF, 1'b0);
        pulse_tick();
        rd(3'd4, v);
        chk("R2 wrap", v, 32'd0);

        // R5: enabled channel sets, disabled channel does not
        wr(3'd0, 32'd10, 1'b0);
        wr(3'd1, 32'd10, 1'b0);
        wr(3'd6, 32'h1, 1'b0);
        wr(3'd4, 32'd10, 1'b0);
        pulse_tick();
        #3;
        chk("R5 irq after match", {28'd0, irq}, 32'h1);
        rd(3'd5, v);
        chk("R5 status register", v, 32'h1);

        // R6: clearing enable leaves status set
        wr(3'd6, 32'h0, 1'b0);
        #3;
        chk("R6 status kept", {28'd0, irq}, 32'h1);

        // R7: write 0 no effect, write 1 clears
        wr(3'd5, 32'h0, 1'b0);
        #3;
        chk("R7 write zero", {28'd0, irq}, 32'h1);
        wr(3'd5, 32'h1, 1'b0);
        #3;
        chk("R7 write one clears", {28'd0, irq}, 32'h0);

        // R7: match wins over clear in same cycle
        wr(3'd6, 32'h1, 1'b0);
        wr(3'd0, 32'd20, 1'b0);
        wr(3'd4, 32'd20, 1'b0);
        pulse_tick();
        wr(3'd4, 32'd20, 1'b0);
        wr(3'd5, 32'h1, 1'b1);
        #3;
        chk("R7 match beats clear", {28'd0, irq}, 32'h1);
        wr(3'd5, 32'h1, 1'b0);
        wr(3'd6, 32'h0, 1'b0);

        // R10: channel 3 match while disarmed raises nothing
        wr(3'd3, 32'd50, 1'b0);
        wr(3'd4, 32'd50, 1'b0);
        pulse_tick();
        #3;
        chk("R10 disarmed no request", {31'd0, wdog_rst_req}, 32'd0);

        // R9: arm, cannot disarm
        wr(3'd7, 32'h1, 1'b0);
        rd(3'd7, v);
        chk("R9 armed reads 1", v, 32'h1);
        wr(3'd7, 32'h0, 1'b0);
        rd(3'd7, v);
        chk("R9 write zero keeps armed", v, 32'h1);
        #3;
        chk("R10 armed no match yet", {31'd0, wdog_rst_req}, 32'd0);

        // R10: bite with channel 3 disabled
        wr(3'd4, 32'd50, 1'b0);
        pulse_tick();
        #3;
        chk("R10 request raised", {31'd0, wdog_rst_req}, 32'd1);
        chk("R10 irq3 stays clear when disabled", {28'd0, irq}, 32'h0);
        repeat (5) @(posedge clk);
        #3;
        chk("R10 request held", {31'd0, wdog_rst_req}, 32'd1);

        // R1 R9: reset clears watchdog
        do_reset();
        #3;
        chk("R1 request cleared by reset", {31'd0, wdog_rst_req}, 32'd0);
        rd(3'd7, v);
        chk("R9 disarmed after reset", v, 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule